// File: doc/BRIEF.md
# Single-Cycle Two-Bit-Correcting Binary Cyclic Codec

This block protects a 256-bit word with 18 check bits. It corrects any one or two flipped bits in the 274-bit stored word. A single `in_mode` pin selects the operation for each accepted word: **encode** builds the check bits for a data word, and **decode** repairs a stored word and reports what it found. Either operation is evaluated combinationally in the cycle the word is accepted. The result lands in an output register one clock later. This gives one operation per clock, with no pipeline depth beyond that register.

The code is a binary cyclic code over GF(2^9), shortened from length 511. Its field is generated by x^9+x^4+1. Encode and decode use the same network, which reduces a 274-bit polynomial modulo the degree-18 generator:
- **Encode** feeds the data shifted above the check-bit positions, and the remainder is the parity.
- **Decode** feeds the received word, and two syndromes S1 and S3 are read off the remainder.

Error positions come from a division-free closed-form test applied at all 274 positions at once. A root-count cross-check rejects patterns the code cannot repair.

Both edges use valid/ready:
- A word is taken on a rising edge where `in_valid` and `in_ready` are both high.
- `in_ready` is high when the output register is empty or its content is being taken in the same edge.
- A held result stays frozen until `out_ready` is seen high.
- Mode and status travel with the result.

Top module: `bch_dec2_codec`

## Requirements
- R1: A word is accepted on a rising edge with `in_valid` and `in_ready` high, and its result is presented with `out_valid` high after that edge. `in_ready` is high whenever no result is held or `out_ready` is high, so one word per cycle can flow. `out_valid` is low out of reset and falls after a result is taken with no new word accepted. `out_status` is never 2'b11.
- R2: While `out_valid` is high and `out_ready` is low, `out_data`, `out_parity`, `out_status` and `out_mode` keep their values, `in_ready` is low, and words offered on `in_valid` are not taken.
- R3: Encode (`in_mode`=0) places data bit j at coefficient x^(j+18) and parity bit k at x^k. It returns `out_data`=`in_data` and an `out_parity` that makes the 274-bit polynomial vanish at α and at α^3, where α is a root of x^9+x^4+1. It reports status 2'b00. `in_parity` has no effect in this mode.
- R4: Decode (`in_mode`=1) of a valid codeword returns status 2'b00 (clean) with data and parity unchanged.
- R5: Decode of a codeword with one flipped bit, at any of the 274 positions, returns status 2'b01 (corrected) and the original data and parity.
- R6: Decode of a codeword with two flipped bits, at any two distinct positions, returns status 2'b01 and the original data and parity.
- R7: If S1 is zero but S3 is not, the decoder returns status 2'b10 (uncorrectable) and passes data and parity through unmodified. An example is flips at positions k, k+4 and k+9.
- R8: If the count of located positions differs from the error count implied by the syndromes, the decoder returns 2'b10 with the word unmodified. Three flips never yield status 2'b00. When decode reports 2'b01, the output is a valid codeword within two bits of the received word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A word is offered |
| in_ready | output | 1 | The block takes the offered word on this edge |
| in_mode | input | 1 | 0 encode, 1 decode |
| in_data | input | 256 | Data word, or data part of the stored word |
| in_parity | input | 18 | Stored check bits (decode only) |
| out_valid | output | 1 | A result is held |
| out_ready | input | 1 | The consumer takes the held result on this edge |
| out_mode | output | 1 | Mode of the held result |
| out_data | output | 256 | Data (corrected in decode) |
| out_parity | output | 18 | Generated or corrected check bits |
| out_status | output | 2 | 00 clean, 01 corrected, 10 uncorrectable |

## Verification
Two things can coincide on one edge: a stalled result is released, and a new word is accepted into the same register. The bench holds a result with `out_ready` low while another word waits on `in_valid`, then raises `out_ready` with that word still offered. The check passes if the first result stayed frozen for the whole stall and the second result appears on the very next cycle, with no cycle lost or duplicated. A back-to-back stream that alternates encode and decode also exercises the case where the shared remainder network serves a different mode on every consecutive edge; each result is judged against its own word.

// File: rtl/bch_dec2_pkg.sv
package bch_dec2_pkg;

  localparam int GF_M = 9;
  localparam logic [GF_M:0] GF_POLY = 10'h211;
  localparam int GF_N = (1 << GF_M) - 1;
  localparam int PAR_W = 2 * GF_M;

  typedef logic [GF_M-1:0] gf_t;

  typedef enum logic [1:0] {
    ST_CLEAN = 2'b00,
    ST_FIXED = 2'b01,
    ST_FAIL  = 2'b10
  } status_e;

  typedef enum logic {
    OP_ENC = 1'b0,
    OP_DEC = 1'b1
  } op_e;

  // Multiply a field element by alpha.
  function automatic gf_t gf_mulx(gf_t a);
    gf_t r;
    r = {a[GF_M-2:0], 1'b0};
    if (a[GF_M-1]) r = r ^ GF_POLY[GF_M-1:0];
    return r;
  endfunction

  // General field multiply.
  function automatic gf_t gf_mul(gf_t a, gf_t b);
    gf_t acc;
    gf_t sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < GF_M; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = gf_mulx(sh);
    end
    return acc;
  endfunction

  // alpha raised to k.
  function automatic gf_t gf_alpha(int k);
    gf_t v;
    int e;
    v = gf_t'(1);
    e = k % GF_N;
    for (int i = 0; i < e; i++) v = gf_mulx(v);
    return v;
  endfunction

  // Generator: product of the minimal polynomials of alpha and alpha^3.
  function automatic logic [PAR_W:0] gen_poly();
    logic [GF_M:0][GF_M-1:0] c;
    logic [GF_M:0] m3;
    logic [PAR_W:0] g;
    gf_t r;
    c = '0;
    c[0] = gf_t'(1);
    for (int j = 0; j < GF_M; j++) begin
      r = gf_alpha(3 * (1 << j));
      for (int k = GF_M; k >= 1; k--) c[k] = c[k-1] ^ gf_mul(c[k], r);
      c[0] = gf_mul(c[0], r);
    end
    for (int k = 0; k <= GF_M; k++) m3[k] = c[k][0];
    g = '0;
    for (int s = 0; s <= GF_M; s++)
      if (GF_POLY[s]) g = g ^ ({{GF_M{1'b0}}, m3} << s);
    return g;
  endfunction

  // x^n reduced modulo the generator.
  function automatic logic [PAR_W-1:0] xpow_mod_g(int n);
    logic [PAR_W:0] g;
    logic [PAR_W-1:0] r;
    g = gen_poly();
    r = '0;
    r[0] = 1'b1;
    for (int i = 0; i < n; i++) begin
      if (r[PAR_W-1]) r = {r[PAR_W-2:0], 1'b0} ^ g[PAR_W-1:0];
      else            r = {r[PAR_W-2:0], 1'b0};
    end
    return r;
  endfunction

endpackage

// File: rtl/bch_rem_net.sv
// Parallel reduction of an N_W-bit polynomial modulo the generator.
// Serves as parity generator (encode) and syndrome front end (decode).
module bch_rem_net
  import bch_dec2_pkg::*;
#(
  parameter int N_W = 274
) (
  input  logic [N_W-1:0]   word,
  output logic [PAR_W-1:0] rem
);

  logic [N_W-1:0][PAR_W-1:0] term;

  for (genvar i = 0; i < N_W; i++) begin : g_term
    localparam logic [PAR_W-1:0] KCOL = xpow_mod_g(i);
    assign term[i] = word[i] ? KCOL : '0;
  end

  always_comb begin
    rem = '0;
    for (int i = 0; i < N_W; i++) rem = rem ^ term[i];
  end

endmodule

// File: rtl/bch_syn.sv
// Maps the 18-bit remainder onto the syndromes at alpha and alpha^3.
module bch_syn
  import bch_dec2_pkg::*;
(
  input  logic [PAR_W-1:0] rem,
  output gf_t              s1,
  output gf_t              s3
);

  logic [PAR_W-1:0][GF_M-1:0] c1;
  logic [PAR_W-1:0][GF_M-1:0] c3;

  for (genvar j = 0; j < PAR_W; j++) begin : g_col
    localparam gf_t A1 = gf_alpha(j);
    localparam gf_t A3 = gf_alpha(3 * j);
    assign c1[j] = rem[j] ? A1 : '0;
    assign c3[j] = rem[j] ? A3 : '0;
  end

  always_comb begin
    s1 = '0;
    s3 = '0;
    for (int j = 0; j < PAR_W; j++) begin
      s1 = s1 ^ c1[j];
      s3 = s3 ^ c3[j];
    end
  end

endmodule

// File: rtl/bch_locate.sv
// Closed-form locator test at every position plus root-count cross-check.
// Position p is in error when S1*b^2 + S1^2*b + (S3 + S1^3) == 0, b = alpha^p.
module bch_locate
  import bch_dec2_pkg::*;
#(
  parameter int N_W = 274
) (
  input  gf_t            s1,
  input  gf_t            s3,
  output logic [N_W-1:0] flip,
  output status_e        status
);

  gf_t  s1_sq;
  gf_t  s1_cu;
  gf_t  dlt;
  logic [N_W-1:0] hit;
  int   nroots;
  logic s1_nz;

  always_comb begin
    s1_sq = gf_mul(s1, s1);
    s1_cu = gf_mul(s1_sq, s1);
    dlt   = s3 ^ s1_cu;
  end

  assign s1_nz = (s1 != '0);

  for (genvar p = 0; p < N_W; p++) begin : g_pos
    localparam gf_t B1 = gf_alpha(p);
    localparam gf_t B2 = gf_alpha(2 * p);
    gf_t lhs;
    assign lhs    = gf_mul(s1, B2) ^ gf_mul(s1_sq, B1) ^ dlt;
    assign hit[p] = s1_nz && (lhs == '0);
  end

  assign nroots = $countones(hit);

  always_comb begin
    flip   = '0;
    status = ST_CLEAN;
    if (!s1_nz) begin
      if (s3 != '0) status = ST_FAIL;
    end else if ((dlt == '0 && nroots == 1) || (dlt != '0 && nroots == 2)) begin
      status = ST_FIXED;
      flip   = hit;
    end else begin
      status = ST_FAIL;
    end
  end

endmodule

// File: rtl/bch_dec2_codec.sv
module bch_dec2_codec
  import bch_dec2_pkg::*;
#(
  parameter int DATA_W = 256
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic                 in_mode,
  input  logic [DATA_W-1:0]    in_data,
  input  logic [2*GF_M-1:0]    in_parity,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic                 out_mode,
  output logic [DATA_W-1:0]    out_data,
  output logic [2*GF_M-1:0]    out_parity,
  output logic [1:0]           out_status
);

  localparam int N_W = DATA_W + PAR_W;

  logic                 is_dec;
  logic [PAR_W-1:0]     par_in;
  logic [N_W-1:0]       work;
  logic [PAR_W-1:0]     rem;
  gf_t                  s1;
  gf_t                  s3;
  logic [N_W-1:0]       flip;
  status_e              dstat;
  logic [N_W-1:0]       fixed_w;
  logic [DATA_W-1:0]    nxt_data;
  logic [PAR_W-1:0]     nxt_par;
  status_e              nxt_stat;
  logic                 fire;

  assign is_dec = (op_e'(in_mode) == OP_DEC);
  assign par_in = is_dec ? in_parity : '0;
  assign work   = {in_data, par_in};

  bch_rem_net #(.N_W(N_W)) u_rem (
    .word (work),
    .rem  (rem)
  );

  bch_syn u_syn (
    .rem (rem),
    .s1  (s1),
    .s3  (s3)
  );

  bch_locate #(.N_W(N_W)) u_loc (
    .s1     (s1),
    .s3     (s3),
    .flip   (flip),
    .status (dstat)
  );

  assign fixed_w = work ^ flip;

  always_comb begin
    if (is_dec) begin
      nxt_data = fixed_w[N_W-1:PAR_W];
      nxt_par  = fixed_w[PAR_W-1:0];
      nxt_stat = dstat;
    end else begin
      nxt_data = in_data;
      nxt_par  = rem;
      nxt_stat = ST_CLEAN;
    end
  end

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_mode   <= 1'b0;
      out_data   <= '0;
      out_parity <= '0;
      out_status <= ST_CLEAN;
    end else if (fire) begin
      out_valid  <= 1'b1;
      out_mode   <= in_mode;
      out_data   <= nxt_data;
      out_parity <= nxt_par;
      out_status <= nxt_stat;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

endmodule

// File: rtl/bch_dec2_chk.sv
module bch_dec2_chk
  import bch_dec2_pkg::*;
#(
  parameter int DATA_W = 256
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic [DATA_W-1:0]    in_data,
  input logic [2*GF_M-1:0]    in_parity,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic                 out_mode,
  input logic [DATA_W-1:0]    out_data,
  input logic [2*GF_M-1:0]    out_parity,
  input logic [1:0]           out_status
);

  logic fire;
  assign fire = in_valid && in_ready;

  a_r1_accept_gives_result: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid);

  a_r1_drain_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !fire) |=> !out_valid);

  a_r1_status_legal: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_status != 2'b11));

  a_r2_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_parity)
                                   && $stable(out_status) && $stable(out_mode)));

  a_r2_stall_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  a_r3_encode_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_mode) |-> (out_status == 2'b00));

  a_r4_clean_unchanged: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fire) && out_mode && out_status == 2'b00)
      |-> ({out_data, out_parity} == $past({in_data, in_parity})));

  a_r5_fix_weight: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fire) && out_status == 2'b01)
      |-> ($countones({out_data, out_parity} ^ $past({in_data, in_parity})) >= 1 &&
           $countones({out_data, out_parity} ^ $past({in_data, in_parity})) <= 2));

  a_r7_fail_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fire) && out_status == 2'b10)
      |-> ({out_data, out_parity} == $past({in_data, in_parity})));

endmodule

bind bch_dec2_codec bch_dec2_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_data    (in_data),
  .in_parity  (in_parity),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_mode   (out_mode),
  .out_data   (out_data),
  .out_parity (out_parity),
  .out_status (out_status)
);

// File: tb/tb_bch_dec2_codec.sv
module tb_bch_dec2_codec;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 256;
  localparam int PW = 18;
  localparam int NW = DW + PW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic          in_mode = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic [PW-1:0] in_parity = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic          out_mode;
  logic [DW-1:0] out_data;
  logic [PW-1:0] out_parity;
  logic [1:0]    out_status;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  bch_dec2_codec #(.DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_data(in_data), .in_parity(in_parity),
    .out_valid(out_valid), .out_ready(out_ready), .out_mode(out_mode),
    .out_data(out_data), .out_parity(out_parity), .out_status(out_status)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [NW-1:0] act, input logic [NW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Independent field arithmetic (shift-and-add, x^9 = x^4 + 1).
  function automatic logic [8:0] tmul(input logic [8:0] a, input logic [8:0] b);
    logic [8:0] p = '0;
    logic [8:0] x = a;
    logic [8:0] y = b;
    for (int i = 0; i < 9; i++) begin
      if (y[0]) p ^= x;
      y = y >> 1;
      x = x[8] ? ({x[7:0], 1'b0} ^ 9'h011) : {x[7:0], 1'b0};
    end
    return p;
  endfunction

  function automatic logic [8:0] eval_at(input logic [NW-1:0] w, input logic [8:0] beta);
    logic [8:0] acc = '0;
    for (int i = NW - 1; i >= 0; i--) acc = tmul(acc, beta) ^ {8'b0, w[i]};
    return acc;
  endfunction

  function automatic bit is_cw(input logic [NW-1:0] w);
    return (eval_at(w, 9'h002) == '0) && (eval_at(w, 9'h008) == '0);
  endfunction

  function automatic logic [DW-1:0] rnd_data();
    logic [DW-1:0] d;
    for (int i = 0; i < DW / 32; i++) d[i*32 +: 32] = $urandom;
    return d;
  endfunction

  task automatic do_op(input logic mode, input logic [DW-1:0] d, input logic [PW-1:0] p,
                       output logic [DW-1:0] od, output logic [PW-1:0] op,
                       output logic [1:0] st, output bit got);
    @(negedge clk);
    in_valid = 1'b1; in_mode = mode; in_data = d; in_parity = p; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    got = out_valid; od = out_data; op = out_parity; st = out_status;
  endtask

  task automatic encode(input logic [DW-1:0] d, input logic [PW-1:0] junk,
                        output logic [PW-1:0] par);
    logic [DW-1:0] od; logic [1:0] st; bit got;
    do_op(1'b0, d, junk, od, par, st, got);
    check(got, "R1", "encode result valid", NW'(got), NW'(1));
    check(st == 2'b00 && od == d, "R3", "encode data/status",
          {od, 16'b0, st}, {d, 18'b0});
    check(is_cw({od, par}), "R3", "encode parity forms codeword", {od, par}, {d, par});
  endtask

  task automatic dec_expect(input string req, input logic [NW-1:0] recv,
                            input logic [1:0] exp_st, input logic [NW-1:0] exp_w);
    logic [DW-1:0] od; logic [PW-1:0] op; logic [1:0] st; bit got;
    do_op(1'b1, recv[NW-1:PW], recv[PW-1:0], od, op, st, got);
    check(got && st == exp_st, req, "decode status", NW'(st), NW'(exp_st));
    check({od, op} == exp_w, req, "decode word", {od, op}, exp_w);
  endtask

  task automatic t_reset();
    check(out_valid == 1'b0, "R1", "out_valid after reset", NW'(out_valid), NW'(0));
    check(in_ready == 1'b1, "R1", "in_ready after reset", NW'(in_ready), NW'(1));
  endtask

  task automatic t_encode();
    logic [PW-1:0] p1; logic [PW-1:0] p2;
    logic [DW-1:0] d;
    encode('0, '0, p1);
    check(p1 == '0, "R3", "zero data gives zero parity", NW'(p1), NW'(0));
    encode('1, '0, p1);
    encode(DW'(1), '0, p1);
    encode({1'b1, {(DW-1){1'b0}}}, '0, p1);
    for (int k = 0; k < 4; k++) begin
      d = rnd_data();
      encode(d, '0, p1);
      encode(d, PW'($urandom), p2);
      check(p1 == p2, "R3", "in_parity ignored in encode", NW'(p2), NW'(p1));
    end
  endtask

  task automatic t_clean();
    logic [DW-1:0] d; logic [PW-1:0] p;
    d = rnd_data(); encode(d, '0, p);
    dec_expect("R4", {d, p}, 2'b00, {d, p});
    encode('0, '0, p);
    dec_expect("R4", {{DW{1'b0}}, p}, 2'b00, {{DW{1'b0}}, p});
  endtask

  task automatic t_single();
    logic [DW-1:0] d; logic [PW-1:0] p; logic [NW-1:0] cw; logic [NW-1:0] r;
    int pos[5] = '{0, 17, 18, 137, 273};
    d = rnd_data(); encode(d, '0, p); cw = {d, p};
    for (int k = 0; k < 10; k++) begin
      int q = (k < 5) ? pos[k] : $urandom_range(0, NW - 1);
      r = cw; r[q] = ~r[q];
      dec_expect("R5", r, 2'b01, cw);
    end
  endtask

  task automatic t_double();
    logic [DW-1:0] d; logic [PW-1:0] p; logic [NW-1:0] cw; logic [NW-1:0] r;
    d = rnd_data(); encode(d, '0, p); cw = {d, p};
    for (int k = 0; k < 8; k++) begin
      int a; int b;
      if (k == 0) begin a = 0; b = 273; end
      else if (k == 1) begin a = 17; b = 18; end
      else begin
        a = $urandom_range(0, NW - 1);
        b = $urandom_range(0, NW - 1);
        while (b == a) b = $urandom_range(0, NW - 1);
      end
      r = cw; r[a] = ~r[a]; r[b] = ~r[b];
      dec_expect("R6", r, 2'b01, cw);
    end
  endtask

  task automatic t_s1_zero();
    logic [DW-1:0] d; logic [PW-1:0] p; logic [NW-1:0] r;
    int ks[3] = '{0, 50, 264};
    d = rnd_data(); encode(d, '0, p);
    for (int k = 0; k < 3; k++) begin
      r = {d, p};
      r[ks[k]] = ~r[ks[k]]; r[ks[k]+4] = ~r[ks[k]+4]; r[ks[k]+9] = ~r[ks[k]+9];
      dec_expect("R7", r, 2'b10, r);
    end
  endtask

  task automatic t_triple();
    logic [DW-1:0] d; logic [PW-1:0] p; logic [NW-1:0] r;
    logic [DW-1:0] od; logic [PW-1:0] op; logic [1:0] st; bit got;
    int nfail = 0;
    d = rnd_data(); encode(d, '0, p);
    for (int k = 0; k < 16; k++) begin
      int a = $urandom_range(0, NW - 1);
      int b = $urandom_range(0, NW - 1);
      int c = $urandom_range(0, NW - 1);
      while (b == a) b = $urandom_range(0, NW - 1);
      while (c == a || c == b) c = $urandom_range(0, NW - 1);
      r = {d, p}; r[a] = ~r[a]; r[b] = ~r[b]; r[c] = ~r[c];
      do_op(1'b1, r[NW-1:PW], r[PW-1:0], od, op, st, got);
      check(got && st != 2'b00 && st != 2'b11, "R8", "three flips not clean",
            NW'(st), NW'(2'b10));
      if (st == 2'b10) begin
        nfail++;
        check({od, op} == r, "R8", "uncorrectable passes through", {od, op}, r);
      end else begin
        check(is_cw({od, op}) && $countones({od, op} ^ r) <= 2, "R8",
              "miscorrection lands on codeword near input", {od, op}, r);
      end
    end
    check(nfail > 0, "R8", "root-count mismatch flagged", NW'(nfail), NW'(1));
  endtask

  task automatic t_backpressure();
    logic [DW-1:0] da; logic [PW-1:0] pa; logic [DW-1:0] db; logic [PW-1:0] pb;
    logic [NW-1:0] ra; logic [NW-1:0] rb;
    logic [DW-1:0] hd; logic [PW-1:0] hp; logic [1:0] hs;
    da = rnd_data(); encode(da, '0, pa);
    db = rnd_data(); encode(db, '0, pb);
    ra = {da, pa}; ra[5] = ~ra[5];
    rb = {db, pb}; rb[200] = ~rb[200]; rb[31] = ~rb[31];
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_mode = 1'b1;
    in_data = ra[NW-1:PW]; in_parity = ra[PW-1:0];
    @(negedge clk);
    check(out_valid && {out_data, out_parity} == {da, pa} && out_status == 2'b01,
          "R5", "stalled result A", {out_data, out_parity}, {da, pa});
    check(in_ready == 1'b0, "R2", "in_ready low while stalled", NW'(in_ready), NW'(0));
    hd = out_data; hp = out_parity; hs = out_status;
    in_data = rb[NW-1:PW]; in_parity = rb[PW-1:0];
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      check(out_valid && {out_data, out_parity} == {hd, hp} && out_status == hs,
            "R2", "held result unchanged", {out_data, out_parity}, {hd, hp});
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && {out_data, out_parity} == {db, pb} && out_status == 2'b01,
          "R1", "release and accept same edge", {out_data, out_parity}, {db, pb});
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "empty after drain", NW'(out_valid), NW'(0));
  endtask

  task automatic t_stream();
    logic [DW-1:0] sd[6]; logic [PW-1:0] sp[6]; logic [NW-1:0] sr[6];
    for (int i = 0; i < 6; i++) begin
      sd[i] = rnd_data(); encode(sd[i], '0, sp[i]);
      sr[i] = {sd[i], sp[i]}; sr[i][i*40] = ~sr[i][i*40];
    end
    for (int i = 0; i <= 6; i++) begin
      @(negedge clk);
      if (i > 0) begin
        if ((i - 1) % 2 == 0)
          check(out_valid && !out_mode && out_data == sd[i-1] && out_parity == sp[i-1],
                "R1", "stream encode result", {out_data, out_parity}, {sd[i-1], sp[i-1]});
        else
          check(out_valid && out_mode && {out_data, out_parity} == {sd[i-1], sp[i-1]}
                && out_status == 2'b01,
                "R1", "stream decode result", {out_data, out_parity}, {sd[i-1], sp[i-1]});
      end
      if (i < 6) begin
        in_valid = 1'b1; in_mode = i[0];
        if (i % 2 == 0) begin in_data = sd[i]; in_parity = PW'($urandom); end
        else begin in_data = sr[i][NW-1:PW]; in_parity = sr[i][PW-1:0]; end
      end else in_valid = 1'b0;
    end
  endtask

  initial begin : main
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_encode();
    t_clean();
    t_single();
    t_double();
    t_s1_zero();
    t_triple();
    t_backpressure();
    t_stream();
    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule